// File: doc/BRIEF.md
# Destructive-Read Core Memory Cycle Sequencer

This block runs one access to a behavioural model of a core-style memory, where reading a location wipes it. An eight-step timing ring drives each access. In the first half the block reads the addressed word, clears the location to zero, keeps the word in a buffer register and checks odd parity on each data byte. In the second half it writes a word back into the location. On a read access this is the buffered word. On a store access it is the new store data. Either way the parity bits are regenerated from the word being written.

A parity failure does not stop the access early. The stop flag comes up only after the write-back has started. The failing location is therefore restored with the word exactly as it was read, including the bad bit, and with parity that is consistent again. The flag stays set and blocks further accesses until it is cleared explicitly. A fault-injection input can force one read bit high for a single access, so detection and restoration can be exercised.

Top module: `core_cycle_seq`

## Requirements
- R1: A start request is accepted only when the block is idle and the stop flag is clear. busy_o then goes high on the next clock and stays high for exactly 8 consecutive cycles, steps T0 to T7.
- R2: A start request made while busy_o is high is ignored. The running access keeps its own address, its operation and its length, and no second access follows it.
- R3: From the clock after T0 until the next read, rdata_o holds the 16-bit word read out of the addressed location.
- R4: A read access puts the word it read back into the location, with freshly generated parity. During T1 to T3 the location holds all zeros.
- R5: A store access writes wdata_i, sampled at the accepting edge, into the location. rdata_o still shows the old contents read in T0.
- R6: Parity is checked per byte. Data bits 7:0 with parity bit 0, and data bits 15:8 with parity bit 1, must each hold an odd number of ones. An even count in either byte flags a parity error.
- R7: A parity error sets par_stop_o at the clock edge that ends T6. The flag is low during T6 and high during T7.
- R8: While par_stop_o is high, no start is accepted. The flag stays high until err_clr_i is asserted. If a set and a clear fall on the same edge, the set wins.
- R9: If fault_en_i is high at the accepting edge, the bit of the read word selected by fault_bit_i is forced to 1 for that access only. Both the parity check and the write-back use the forced word.
- R10: After reset, busy_o, par_stop_o and rdata_o are 0, and every location holds zero data with valid parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request for one memory access |
| addr_i | input | ADDR_W | Word address, sampled when the request is accepted |
| store_i | input | 1 | 1 = store access, 0 = read access |
| wdata_i | input | 16 | Store data, sampled when the request is accepted |
| fault_en_i | input | 1 | Force one read bit high during this access |
| fault_bit_i | input | 4 | Index of the bit to force |
| err_clr_i | input | 1 | Clears the parity stop flag |
| rdata_o | output | 16 | Word read in the most recent access |
| busy_o | output | 1 | Access in progress, steps T0 to T7 |
| par_stop_o | output | 1 | Sticky parity-error stop flag |

## Verification
The assertions run on every cycle. They check that the ring advances one step per clock and stops after T7, and that the location reads as zero during T1 to T3 and matches the buffer at T5. They also check that the stop flag rises only out of T6, stays set until cleared, and keeps the block idle while set. Only the bench scenarios can show the end-to-end results: that a later read returns the corrupted word without a new error, that stores replace the word while reporting the old one, and that requests made during an access or while stopped leave the memory and the cycle count unchanged.

// File: rtl/core_cycle_pkg.sv
package core_cycle_pkg;
  parameter int unsigned WORD_W    = 16;
  parameter int unsigned BYTE_W    = 8;
  parameter int unsigned NBYTE     = WORD_W / BYTE_W;
  parameter int unsigned BIT_IDX_W = $clog2(WORD_W);
  parameter int unsigned STEP_W    = 3;
  parameter int unsigned TOT_W     = WORD_W + NBYTE;

  // step numbers at which the cycle's events happen
  parameter logic [STEP_W-1:0] CAPTURE_STEP = 3'd0;
  parameter logic [STEP_W-1:0] LOAD_STEP    = 3'd3;
  parameter logic [STEP_W-1:0] WRITE_STEP   = 3'd4;
  parameter logic [STEP_W-1:0] STOP_STEP    = 3'd6;
  parameter logic [STEP_W-1:0] LAST_STEP    = 3'd7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NBYTE-1:0]  par_t;

  // odd parity bit per byte: set when the byte holds an even count of ones
  function automatic par_t gen_par(word_t w);
    par_t p;
    for (int b = 0; b < NBYTE; b++) p[b] = ~(^w[b*BYTE_W +: BYTE_W]);
    return p;
  endfunction

  // per-byte error flag: byte plus its parity bit holds an even count of ones
  function automatic par_t chk_par(word_t w, par_t p);
    par_t bad;
    for (int b = 0; b < NBYTE; b++) bad[b] = ~(^{w[b*BYTE_W +: BYTE_W], p[b]});
    return bad;
  endfunction
endpackage

// File: rtl/cyc_ring.sv
module cyc_ring
  import core_cycle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              hold_i,
  output logic              accept_o,
  output logic              active_o,
  output logic [STEP_W-1:0] step_o
);
  logic              active_q;
  logic [STEP_W-1:0] step_q;

  assign accept_o = start_i & ~active_q & ~hold_i;
  assign active_o = active_q;
  assign step_o   = step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      step_q   <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      step_q   <= '0;
    end else if (active_q) begin
      if (step_q == LAST_STEP) active_q <= 1'b0;
      else                     step_q   <= step_q + 1'b1;
    end
  end

  p_step_adv_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && step_q != LAST_STEP) |=> (active_q && step_q == STEP_W'($past(step_q) + 1)));

  p_cycle_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && step_q == LAST_STEP) |=> !active_q);

  p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start_i && step_q != LAST_STEP) |=> (step_q != '0));
endmodule

// File: rtl/core_store.sv
module core_store
  import core_cycle_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_en_i,
  input  logic              wr_en_i,
  input  logic [TOT_W-1:0]  wr_word_i,
  output logic [TOT_W-1:0]  rd_word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [TOT_W-1:0] INIT_WORD = {{NBYTE{1'b1}}, {WORD_W{1'b0}}};

  logic [TOT_W-1:0] cells [DEPTH];

  assign rd_word_o = cells[addr_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= INIT_WORD;
    end else if (wr_en_i) begin
      cells[addr_i] <= wr_word_i;
    end else if (clr_en_i) begin
      cells[addr_i] <= '0;
    end
  end
endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
  import core_cycle_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 store_i,
  input  logic [WORD_W-1:0]    wdata_i,
  input  logic                 fault_en_i,
  input  logic [BIT_IDX_W-1:0] fault_bit_i,
  input  logic                 err_clr_i,
  output logic [WORD_W-1:0]    rdata_o,
  output logic                 busy_o,
  output logic                 par_stop_o
);
  logic              accept, active;
  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] addr_q;
  logic              store_q, perr_q, stop_q;
  word_t             wdata_q, fmask_q, buf_q, rdata_q, read_word;
  logic [TOT_W-1:0]  loc_word, wr_word;

  // named cycle events
  logic cap_evt, load_evt, wr_evt, stop_evt;
  assign cap_evt  = active && step == CAPTURE_STEP;
  assign load_evt = active && step == LOAD_STEP && store_q;
  assign wr_evt   = active && step == WRITE_STEP;
  assign stop_evt = active && step == STOP_STEP && perr_q;

  cyc_ring u_ring (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(stop_q),
    .accept_o(accept), .active_o(active), .step_o(step)
  );

  assign read_word = loc_word[WORD_W-1:0] | fmask_q;
  assign wr_word   = {gen_par(buf_q), buf_q};

  core_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_q), .clr_en_i(cap_evt),
    .wr_en_i(wr_evt), .wr_word_i(wr_word), .rd_word_o(loc_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      store_q <= 1'b0;
      wdata_q <= '0;
      fmask_q <= '0;
      buf_q   <= '0;
      rdata_q <= '0;
      perr_q  <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        store_q <= store_i;
        wdata_q <= wdata_i;
        fmask_q <= fault_en_i ? (word_t'(1) << fault_bit_i) : '0;
      end
      if (cap_evt) begin
        buf_q   <= read_word;
        rdata_q <= read_word;
        perr_q  <= |chk_par(read_word, loc_word[TOT_W-1:WORD_W]);
      end else if (load_evt) begin
        buf_q <= wdata_q;
      end
      if (stop_evt)       stop_q <= 1'b1;
      else if (err_clr_i) stop_q <= 1'b0;
    end
  end

  assign rdata_o    = rdata_q;
  assign busy_o     = active;
  assign par_stop_o = stop_q;

  p_loc_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step >= 3'd1 && step <= LOAD_STEP) |-> (loc_word == '0));

  p_loc_restored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == 3'd5) |-> (loc_word[WORD_W-1:0] == buf_q &&
                                  chk_par(loc_word[WORD_W-1:0], loc_word[TOT_W-1:WORD_W]) == '0));

  p_store_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && store_q) |-> (buf_q == wdata_q));

  p_stop_at_t6_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_q) |-> ($past(active) && $past(step) == STOP_STEP));

  p_stop_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !active) |=> !active);

  p_stop_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !err_clr_i) |=> stop_q);
endmodule

// File: tb/tb_core_cycle_seq.sv
`timescale 1ns/1ps
module tb_core_cycle_seq;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, store_i = 1'b0, fault_en_i = 1'b0, err_clr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [3:0] fault_bit_i = '0;
  logic [15:0] rdata_o;
  logic busy_o, par_stop_o;

  int checks = 0, errors = 0;
  logic [15:0] model [DEPTH];

  always #2 clk = ~clk;

  core_cycle_seq #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .store_i(store_i),
    .wdata_i(wdata_i), .fault_en_i(fault_en_i), .fault_bit_i(fault_bit_i),
    .err_clr_i(err_clr_i), .rdata_o(rdata_o), .busy_o(busy_o), .par_stop_o(par_stop_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // expected read value: forced bit makes the word differ only if it was 0
  function automatic logic [15:0] forced(input logic [15:0] w, input logic fe, input logic [3:0] fb);
    logic [15:0] r = w;
    if (fe) r[fb] = 1'b1;
    return r;
  endfunction

  // stored parity is always valid, so an error appears exactly when a forced bit flips
  function automatic logic expect_err(input logic [15:0] w, input logic fe, input logic [3:0] fb);
    return fe && (w[fb] == 1'b0);
  endfunction

  task automatic run_op(input logic [AW-1:0] a, input logic st, input logic [15:0] wd,
                        input logic fe, input logic [3:0] fb, input logic poke);
    logic [15:0] exp_rd;
    logic exp_e;
    exp_rd = forced(model[a], fe, fb);
    exp_e  = expect_err(model[a], fe, fb);
    @(negedge clk);
    start_i = 1'b1; addr_i = a; store_i = st; wdata_i = wd; fault_en_i = fe; fault_bit_i = fb;
    @(negedge clk);                        // n0: inside T0
    start_i = 1'b0; fault_en_i = 1'b0; addr_i = ~a; store_i = ~st; wdata_i = ~wd;
    check("R1 busy at T0", busy_o, 1);
    for (int k = 1; k <= 8; k++) begin
      if (poke && k == 2) start_i = 1'b1;  // R2: request while busy
      if (poke && k == 4) start_i = 1'b0;
      @(negedge clk);
      if (k == 1) begin
        check(st ? "R5 old word on rdata" : "R3 read data", rdata_o, exp_rd);
        if (fe) check("R9 forced bit seen", rdata_o[fb], 1);
      end
      if (k == 6) check("R7 stop low during T6", par_stop_o, 0);
      if (k == 7) begin
        check("R7/R6 stop during T7", par_stop_o, exp_e);
        check("R1 busy at T7", busy_o, 1);
      end
      if (k == 8) check("R1 busy ends after T7", busy_o, 0);
    end
    start_i = 1'b0;
    if (poke) begin
      @(negedge clk);
      check("R2 no second cycle", busy_o, 0);
    end
    check("R3 rdata held", rdata_o, exp_rd);
    model[a] = st ? wd : exp_rd;
    if (exp_e) begin
      start_i = 1'b1; addr_i = a; store_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      check("R8 start blocked by stop", busy_o, 0);
      check("R8 stop sticky", par_stop_o, 1);
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      check("R8 stop cleared", par_stop_o, 0);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [15:0] sav;
    void'($urandom(32'd1130));
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 busy after reset", busy_o, 0);
    check("R10 stop after reset", par_stop_o, 0);
    check("R10 rdata after reset", rdata_o, 0);
    run_op(6'd5, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);           // R10: zero word, no error
    run_op(6'd5, 1'b1, 16'hA5C3, 1'b0, 4'd0, 1'b0);        // R5 store
    run_op(6'd5, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);           // R4 read back
    run_op(6'd5, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);           // R4 still intact
    // R6/R9 low byte error: bit 2 of A5C3 is 0
    run_op(6'd5, 1'b0, 16'h0, 1'b1, 4'd2, 1'b0);
    sav = model[5];
    check("R4 corrupted word model", sav, 16'hA5C7);
    run_op(6'd5, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);           // R4 corrupted word, valid parity
    // R6 high byte error: bit 8 of A5C7 is 1 -> no error; bit 9 is 0 -> error
    run_op(6'd5, 1'b0, 16'h0, 1'b1, 4'd8, 1'b0);
    run_op(6'd5, 1'b0, 16'h0, 1'b1, 4'd9, 1'b0);
    // R9 store with fault: error reported, new data still written
    run_op(6'd7, 1'b1, 16'h1234, 1'b1, 4'd15, 1'b0);
    run_op(6'd7, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);
    // R2 request while busy, then check the other address is untouched
    run_op(6'd9, 1'b1, 16'h0F0F, 1'b0, 4'd0, 1'b1);
    run_op(~6'd9, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);
    run_op(6'd9, 1'b0, 16'h0, 1'b0, 4'd0, 1'b0);
    // R8 clear and set on the same edge: set wins
    begin
      logic [15:0] r;
      r = forced(model[3], 1'b1, 4'd0);
      @(negedge clk);
      start_i = 1'b1; addr_i = 6'd3; store_i = 1'b0; fault_en_i = 1'b1; fault_bit_i = 4'd0;
      @(negedge clk);
      start_i = 1'b0; fault_en_i = 1'b0;
      repeat (6) @(negedge clk);           // now in T6
      err_clr_i = 1'b1;
      @(negedge clk);                      // in T7
      err_clr_i = 1'b0;
      check("R8 set beats clear", par_stop_o, 1);
      @(negedge clk);
      err_clr_i = 1'b1;
      @(negedge clk);
      err_clr_i = 1'b0;
      check("R8 stop cleared after tie", par_stop_o, 0);
      model[3] = r;
    end
    // constrained random mix
    for (int n = 0; n < 150; n++) begin
      logic [AW-1:0] a;
      logic st, fe;
      a  = AW'($urandom_range(0, 15));
      st = ($urandom_range(0, 2) == 0);
      fe = ($urandom_range(0, 5) == 0);
      run_op(a, st, 16'($urandom), fe, 4'($urandom_range(0, 15)), ($urandom_range(0, 9) == 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule